// File: doc/BRIEF.md
# Virtual interrupt list register slot

This block is one slot of the list of virtual interrupts that a virtualization-aware interrupt CPU interface presents to a guest. The hypervisor fills the slot through a load port. A load carries a virtual interrupt number, a two-bit state, a flag that links the slot to a physical interrupt and, for a linked slot, the physical interrupt number. The guest then takes the interrupt with an acknowledge strobe, which returns the virtual number, and retires it with an end-of-interrupt strobe or a separate deactivate strobe. A split-mode input selects which of the two retires the interrupt.

When a linked slot is deactivated by the guest, the block sends a one-cycle deactivate request carrying the physical number to the distributor. The physical interrupt then leaves its active state at the same moment as the virtual one. A linked slot cannot hold pending and active together, and an interrupt class with no active state cannot be linked. Loads that break either rule are refused and flagged. An empty output tells the hypervisor when the slot is free to clear or reuse.

Top module: `lrs_slot`

## Requirements
- R1: A synchronous active-high reset clears the slot: state Inactive (00), link flag 0, empty 1, acknowledge ID all ones, error and deactivate request 0.
- R2: The state code is 00 Inactive, 01 Pending, 10 Active, 11 Pending+Active. An accepted load writes the virtual ID, state, link flag and physical ID, and these appear on the slot outputs one cycle later. The empty output is high exactly when the state is Inactive.
- R3: An acknowledge while the slot is Pending or Pending+Active returns the virtual ID on ack_id one cycle later and moves the state to Active.
- R4: An acknowledge in any other state returns all ones on ack_id one cycle later and leaves the state unchanged. ack_id holds its value in cycles with no acknowledge.
- R5: A deactivation moves Active to Inactive and Pending+Active to Pending, and has no effect in Inactive or Pending. With split_mode 0, either the deactivate strobe or the end-of-interrupt strobe deactivates.
- R6: With split_mode 1, the end-of-interrupt strobe has no effect on the slot, and only the deactivate strobe deactivates.
- R7: A deactivation that takes a linked slot from Active to Inactive raises fwd_valid for exactly one cycle, one cycle later, with fwd_pid equal to the stored physical ID. No request is made for an unlinked slot or for any other transition.
- R8: A load with the link flag set and state Pending+Active is refused. ld_err is high for one cycle, one cycle later, and the slot contents stay unchanged.
- R9: A load with the link flag set and ld_noact high (an interrupt class with no active state) is refused in the same way. A load with ld_noact high and the link flag clear is accepted.
- R10: In a cycle with ld_valid high, whether the load is accepted or refused, guest strobes are ignored. An acknowledge in that cycle returns all ones, and no deactivate request results.
- R11: When acknowledge and a deactivation arrive in the same cycle, only the acknowledge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Hypervisor load strobe |
| ld_vid | input | VID_W | Virtual interrupt ID to load |
| ld_state | input | 2 | State to load |
| ld_hw | input | 1 | Link flag to load |
| ld_pid | input | PID_W | Physical interrupt ID to load |
| ld_noact | input | 1 | Interrupt class of the load has no active state |
| ld_err | output | 1 | Previous load was refused |
| g_ack | input | 1 | Guest acknowledge strobe |
| g_eoi | input | 1 | Guest end-of-interrupt strobe |
| g_dir | input | 1 | Guest deactivate strobe |
| split_mode | input | 1 | 1: only g_dir deactivates |
| ack_id | output | VID_W | Acknowledge result |
| slot_vid | output | VID_W | Stored virtual ID |
| slot_state | output | 2 | Stored state |
| slot_hw | output | 1 | Stored link flag |
| slot_pid | output | PID_W | Stored physical ID |
| slot_empty | output | 1 | Slot is Inactive |
| fwd_valid | output | 1 | Deactivate request to distributor |
| fwd_pid | output | PID_W | Physical ID of the request |

## Verification
The bench targets the deactivation corner cases. Pending+Active must fall back to Pending rather than to Inactive, or a pending interrupt would be lost. A linked Pending slot must make no distributor request, since a spurious request would retire a physical interrupt the guest never took. It also covers a load and a strobe in the same cycle: a design that let the guest strobe through would retire or acknowledge an interrupt just overwritten. It checks simultaneous acknowledge and deactivate, and the end-of-interrupt strobe in split mode. The refused linked loads are checked too, since a design that took them would hold a state the distributor cannot mirror.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    ST_INACT = 2'b00,
    ST_PEND  = 2'b01,
    ST_ACT   = 2'b10,
    ST_PA    = 2'b11
  } lr_state_e;
endpackage

// File: rtl/lrs_load_check.sv
module lrs_load_check
  import lrs_pkg::*;
(
  input  logic [1:0] ld_state,
  input  logic       ld_hw,
  input  logic       ld_noact,
  output logic       ld_ok
);
  // A linked slot must be able to mirror the physical active state.
  always_comb begin
    ld_ok = 1'b1;
    if (ld_hw && (lr_state_e'(ld_state) == ST_PA)) ld_ok = 1'b0;
    if (ld_hw && ld_noact) ld_ok = 1'b0;
  end
endmodule

// File: rtl/lrs_state_core.sv
module lrs_state_core
  import lrs_pkg::*;
#(
  parameter int VID_W = 10,
  parameter int PID_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic             ld_ok,
  input  logic [VID_W-1:0] ld_vid,
  input  logic [1:0]       ld_state,
  input  logic             ld_hw,
  input  logic [PID_W-1:0] ld_pid,
  input  logic             g_ack,
  input  logic             g_eoi,
  input  logic             g_dir,
  input  logic             split_mode,
  output logic [VID_W-1:0] vid_q,
  output lr_state_e        state_q,
  output logic             hw_q,
  output logic [PID_W-1:0] pid_q,
  output logic             empty_q,
  output logic [VID_W-1:0] ack_id_q,
  output logic             ld_err_q,
  output logic             fwd_fire
);
  localparam logic [VID_W-1:0] SPUR_ID = {VID_W{1'b1}};

  logic      guest_ok, do_ack, do_deact, acked, ld_take;
  lr_state_e st_n;

  always_comb begin
    guest_ok = !ld_valid;
    ld_take  = ld_valid && ld_ok;
    do_ack   = guest_ok && g_ack;
    do_deact = guest_ok && !g_ack && (g_dir || (g_eoi && !split_mode));
    acked    = do_ack && ((state_q == ST_PEND) || (state_q == ST_PA));
    fwd_fire = do_deact && hw_q && (state_q == ST_ACT);
    st_n     = state_q;
    if (ld_take) begin
      st_n = lr_state_e'(ld_state);
    end else if (acked) begin
      st_n = ST_ACT;
    end else if (do_deact) begin
      case (state_q)
        ST_ACT:  st_n = ST_INACT;
        ST_PA:   st_n = ST_PEND;
        default: st_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q    <= '0;
      state_q  <= ST_INACT;
      hw_q     <= 1'b0;
      pid_q    <= '0;
      empty_q  <= 1'b1;
      ack_id_q <= SPUR_ID;
      ld_err_q <= 1'b0;
    end else begin
      state_q  <= st_n;
      empty_q  <= (st_n == ST_INACT);
      ld_err_q <= ld_valid && !ld_ok;
      if (ld_take) begin
        vid_q <= ld_vid;
        hw_q  <= ld_hw;
        pid_q <= ld_pid;
      end
      if (g_ack) ack_id_q <= acked ? vid_q : SPUR_ID;
    end
  end

  // R8
  linked_no_pa_chk: assert property (@(posedge clk) disable iff (rst)
    hw_q |-> (state_q != ST_PA));

  // R8
  refused_keeps_slot_chk: assert property (@(posedge clk) disable iff (rst)
    ld_err_q |-> ($stable(state_q) && $stable(vid_q) && $stable(hw_q) && $stable(pid_q)));

  // R4
  spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (g_ack && !ld_valid && (state_q == ST_INACT)) |=> (ack_id_q == SPUR_ID));

  // R5
  deact_active_chk: assert property (@(posedge clk) disable iff (rst)
    (g_dir && !g_ack && !ld_valid && (state_q == ST_ACT)) |=> (state_q == ST_INACT));
endmodule

// File: rtl/lrs_fwd.sv
module lrs_fwd #(
  parameter int PID_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [PID_W-1:0] pid,
  output logic             fwd_valid,
  output logic [PID_W-1:0] fwd_pid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_pid   <= '0;
    end else begin
      fwd_valid <= fire;
      if (fire) fwd_pid <= pid;
    end
  end

  // R7
  fwd_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |=> !fwd_valid);
endmodule

// File: rtl/lrs_slot.sv
module lrs_slot
  import lrs_pkg::*;
#(
  parameter int VID_W = 10,
  parameter int PID_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [VID_W-1:0] ld_vid,
  input  logic [1:0]       ld_state,
  input  logic             ld_hw,
  input  logic [PID_W-1:0] ld_pid,
  input  logic             ld_noact,
  output logic             ld_err,
  input  logic             g_ack,
  input  logic             g_eoi,
  input  logic             g_dir,
  input  logic             split_mode,
  output logic [VID_W-1:0] ack_id,
  output logic [VID_W-1:0] slot_vid,
  output logic [1:0]       slot_state,
  output logic             slot_hw,
  output logic [PID_W-1:0] slot_pid,
  output logic             slot_empty,
  output logic             fwd_valid,
  output logic [PID_W-1:0] fwd_pid
);
  logic      ld_ok, fire;
  lr_state_e st;

  lrs_load_check u_chk (
    .ld_state (ld_state),
    .ld_hw    (ld_hw),
    .ld_noact (ld_noact),
    .ld_ok    (ld_ok)
  );

  lrs_state_core #(.VID_W(VID_W), .PID_W(PID_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .ld_valid   (ld_valid),
    .ld_ok      (ld_ok),
    .ld_vid     (ld_vid),
    .ld_state   (ld_state),
    .ld_hw      (ld_hw),
    .ld_pid     (ld_pid),
    .g_ack      (g_ack),
    .g_eoi      (g_eoi),
    .g_dir      (g_dir),
    .split_mode (split_mode),
    .vid_q      (slot_vid),
    .state_q    (st),
    .hw_q       (slot_hw),
    .pid_q      (slot_pid),
    .empty_q    (slot_empty),
    .ack_id_q   (ack_id),
    .ld_err_q   (ld_err),
    .fwd_fire   (fire)
  );

  lrs_fwd #(.PID_W(PID_W)) u_fwd (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .pid       (slot_pid),
    .fwd_valid (fwd_valid),
    .fwd_pid   (fwd_pid)
  );

  assign slot_state = st;

  // R7
  fwd_from_linked_active_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> ($past(slot_hw && (st == ST_ACT)) && (st == ST_INACT)));

  // R10
  load_blocks_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !fwd_valid);

  // R8
  err_needs_bad_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld_err |-> $past(ld_valid && ld_hw && ((ld_state == 2'b11) || ld_noact)));
endmodule

// File: tb/sim_lrs_slot.sv
`timescale 1ns/1ps
module sim_lrs_slot;
  localparam int VW = 10;
  localparam int PW = 10;
  localparam logic [VW-1:0] SPUR = {VW{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 0, ld_hw = 0, ld_noact = 0;
  logic [VW-1:0] ld_vid = '0;
  logic [1:0] ld_state = 2'b00;
  logic [PW-1:0] ld_pid = '0;
  logic g_ack = 0, g_eoi = 0, g_dir = 0, split_mode = 0;
  logic ld_err, slot_hw, slot_empty, fwd_valid;
  logic [VW-1:0] ack_id, slot_vid;
  logic [1:0] slot_state;
  logic [PW-1:0] slot_pid, fwd_pid;

  always #5 clk = ~clk;

  lrs_slot #(.VID_W(VW), .PID_W(PW)) u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_vid(ld_vid), .ld_state(ld_state),
    .ld_hw(ld_hw), .ld_pid(ld_pid), .ld_noact(ld_noact), .ld_err(ld_err),
    .g_ack(g_ack), .g_eoi(g_eoi), .g_dir(g_dir), .split_mode(split_mode),
    .ack_id(ack_id), .slot_vid(slot_vid), .slot_state(slot_state), .slot_hw(slot_hw),
    .slot_pid(slot_pid), .slot_empty(slot_empty), .fwd_valid(fwd_valid), .fwd_pid(fwd_pid)
  );

  // reference model
  int m_vid, m_st, m_hw, m_pid, m_ack, m_fwd, m_fpid, m_err;
  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_vid = 0; m_st = 0; m_hw = 0; m_pid = 0; m_ack = int'(SPUR);
      m_fwd = 0; m_fpid = 0; m_err = 0;
    end else begin
      m_fwd = 0;
      m_err = 0;
      if (ld_valid) begin
        if (ld_hw && (ld_state == 2'b11 || ld_noact)) m_err = 1;
        else begin
          m_vid = int'(ld_vid); m_st = int'(ld_state);
          m_hw = int'(ld_hw); m_pid = int'(ld_pid);
        end
        if (g_ack) m_ack = int'(SPUR);
      end else if (g_ack) begin
        if (m_st == 1 || m_st == 3) begin
          m_ack = m_vid; m_st = 2;
        end else m_ack = int'(SPUR);
      end else if (g_dir || (g_eoi && !split_mode)) begin
        if (m_st == 2) begin
          m_st = 0;
          if (m_hw == 1) begin m_fwd = 1; m_fpid = m_pid; end
        end else if (m_st == 3) m_st = 1;
      end
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "state", int'(slot_state), m_st);
      check(cur_req, "vid", int'(slot_vid), m_vid);
      check(cur_req, "hw", int'(slot_hw), m_hw);
      check(cur_req, "pid", int'(slot_pid), m_pid);
      check(cur_req, "empty", int'(slot_empty), (m_st == 0) ? 1 : 0);
      check(cur_req, "ack_id", int'(ack_id), m_ack);
      check(cur_req, "ld_err", int'(ld_err), m_err);
      check(cur_req, "fwd_valid", int'(fwd_valid), m_fwd);
      if (m_fwd == 1) check(cur_req, "fwd_pid", int'(fwd_pid), m_fpid);
    end
  end

  task automatic idle();
    @(negedge clk);
    ld_valid = 0; g_ack = 0; g_eoi = 0; g_dir = 0; ld_noact = 0; ld_hw = 0;
  endtask

  task automatic op(bit ld, int vid, int st, bit hw, int pid, bit noact,
                    bit ack, bit eoi, bit dir);
    @(negedge clk);
    ld_valid = ld; ld_vid = VW'(vid); ld_state = 2'(st); ld_hw = hw;
    ld_pid = PW'(pid); ld_noact = noact; g_ack = ack; g_eoi = eoi; g_dir = dir;
  endtask

  task automatic load(int vid, int st, bit hw, int pid, bit noact);
    op(1, vid, st, hw, pid, noact, 0, 0, 0); idle();
  endtask

  task automatic guest(bit ack, bit eoi, bit dir);
    op(0, 0, 0, 0, 0, 0, ack, eoi, dir); idle();
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(); idle();
    cur_req = "R2";
    load(5, 1, 0, 3, 0);
    load(7, 0, 0, 0, 0);
    load(9, 3, 0, 4, 0);
    cur_req = "R3";
    load(12'h21, 1, 0, 0, 0); guest(1, 0, 0);
    load(12'h33, 3, 0, 0, 0); guest(1, 0, 0);
    cur_req = "R4";
    guest(1, 0, 0);
    load(4, 0, 0, 0, 0); guest(1, 0, 0); idle();
    cur_req = "R5";
    load(6, 2, 0, 0, 0); guest(0, 0, 1);
    load(6, 3, 0, 0, 0); guest(0, 0, 1);
    guest(0, 0, 1);
    split_mode = 0;
    load(8, 2, 0, 0, 0); guest(0, 1, 0);
    cur_req = "R6";
    split_mode = 1;
    load(10, 2, 1, 9, 0); guest(0, 1, 0); guest(0, 1, 0); guest(0, 0, 1);
    split_mode = 0;
    cur_req = "R7";
    load(11, 2, 1, 10'h155, 0); guest(0, 0, 1); idle();
    load(12, 1, 1, 10'h0AA, 0); guest(0, 0, 1); guest(1, 0, 0); guest(0, 1, 0);
    load(13, 2, 0, 10'h077, 0); guest(0, 0, 1);
    cur_req = "R8";
    load(14, 2, 0, 1, 0); load(15, 3, 1, 2, 0);
    cur_req = "R9";
    load(16, 1, 1, 3, 1); load(17, 1, 0, 3, 1);
    cur_req = "R10";
    load(18, 1, 0, 0, 0);
    op(1, 19, 2, 1, 5, 0, 1, 0, 0); idle();
    op(1, 20, 2, 1, 6, 0, 0, 0, 1); idle();
    op(1, 21, 3, 1, 6, 0, 0, 0, 1); idle(); idle();
    cur_req = "R11";
    load(22, 1, 0, 0, 0); op(0, 0, 0, 0, 0, 0, 1, 0, 1); idle();
    load(23, 2, 1, 7, 0); op(0, 0, 0, 0, 0, 0, 1, 1, 1); idle(); idle();
    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      split_mode = ($urandom_range(0, 3) == 0);
      op(r < 3, int'($urandom_range(0, 1023)), int'($urandom_range(0, 3)),
         ($urandom_range(0, 1) == 1), int'($urandom_range(0, 1023)),
         ($urandom_range(0, 4) == 0),
         ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0),
         ($urandom_range(0, 2) == 0));
    end
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule